// File: doc/BRIEF.md
# Right-to-Left Exponentiation Sequencer

This controller runs binary modular exponentiation with the exponent scanned from the least significant bit upward. It drives two external modular multiplier units through start/done handshakes. On every exponent bit, the squaring unit replaces the running power with its square. In the same cycle, the product unit replaces the running result with result times power, but only when the bit is one. The two units therefore run in parallel. A step ends only when every unit that was launched for it has answered.

The multipliers and the operand memories are outside the block. The sequencer gives the exponent bit index to an external bit store. That store returns the bit one cycle later. The sequencer pulses a load strobe so the datapath can seed power buffer 0 with the base and result buffer 0 with one. It also drives two ping-pong select lines, one for the power pair and one for the result pair. The multipliers read the selected buffer and write its partner. When `valid_o` rises, `res_sel_o` names the buffer that holds the answer.

Top module: `rl_exp_seq`

## Requirements
- R1: After reset, `busy_o`, `valid_o`, `load_o`, `sqr_start_o` and `mul_start_o` are low, and `pwr_sel_o`, `res_sel_o` and `exp_idx_o` are 0.
- R2: A `start_i` sampled while idle has these effects on the next cycle: `busy_o` goes high, `valid_o` goes low, both selects and `exp_idx_o` return to 0, and `load_o` pulses for exactly that one cycle. The bit count is taken from `exp_len_i` on that same edge.
- R3: `sqr_start_o` pulses once per exponent bit. When it is launched together with a product, both start strobes are high in the same cycle.
- R4: Bits are read least significant first, at indices 0 up to length-1. The index is presented for one cycle, and `exp_bit_i` is sampled in the following cycle, which is the issue cycle.
- R5: A step advances only after a done pulse has been seen from the squaring unit and, if it was launched, from the product unit. The pulses may come in any order and with any latency of at least one cycle.
- R6: On a zero bit, `mul_start_o` stays low and `res_sel_o` does not change, so the result is carried over unchanged.
- R7: `pwr_sel_o` toggles after every completed step. `res_sel_o` toggles only after steps whose bit is one. Units read the selected buffer and write the other one.
- R8: In the cycle after the last step completes, `busy_o` falls and `valid_o` rises. The buffer named by `res_sel_o` then holds base^exponent mod m.
- R9: A bit count of 0 finishes right after the load cycle, with no multiplier started. `res_sel_o` is then 0, so the answer is the seeded value one.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. The run keeps its original bit count and its result.
- R11: `valid_o` stays high while idle, until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request, accepted only while idle |
| exp_len_i | input | CNT_W | Number of exponent bits to process |
| exp_idx_o | output | CNT_W | Index of the exponent bit being fetched |
| exp_bit_i | input | 1 | Exponent bit, one cycle after its index |
| load_o | output | 1 | Seed strobe: power buffer 0 gets the base, result buffer 0 gets one |
| sqr_start_o | output | 1 | Start pulse to the squaring unit |
| sqr_done_i | input | 1 | Done pulse from the squaring unit |
| mul_start_o | output | 1 | Start pulse to the product unit |
| mul_done_i | input | 1 | Done pulse from the product unit |
| pwr_sel_o | output | 1 | Power buffer read by both units; the squarer writes the other |
| res_sel_o | output | 1 | Result buffer read by the product unit; final answer location |
| busy_o | output | 1 | Run in progress |
| valid_o | output | 1 | Result final |

## Verification
The hardest case to reach is a step where the two units finish in different orders and at different times. The wait stage must hold off until the later done, and it must not advance on the earlier one. To create this, the bench models the multipliers with latencies set per run, with squaring slower in one run and the product slower in another. In a third run both latencies are equal. The exponents mix runs of ones and zeros, so some steps wait on two units and others on one. A second start is also pushed into the middle of a long run, to show that the run is not disturbed.

// File: rtl/rl_exp_pkg.sv
package rl_exp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/rl_exp_bit_ctr.sv
module rl_exp_bit_ctr #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  localparam int unsigned W1 = CNT_W + 1;

  logic [CNT_W-1:0] idx_q;
  logic [W1-1:0]    nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (inc_i) idx_q <= idx_q + 1'b1;
  end

  assign nxt    = {1'b0, idx_q} + W1'(1);
  assign last_o = (nxt == {1'b0, len_i});
  assign idx_o  = idx_q;

  // stepping never runs past the programmed length
  p_idx_below_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (idx_q < len_i));
endmodule

// File: rtl/rl_exp_done_join.sv
module rl_exp_done_join (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic need_mul_i,
  input  logic sqr_done_i,
  input  logic mul_done_i,
  output logic both_o
);
  logic sq_seen_q, mu_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_seen_q <= 1'b0;
      mu_seen_q <= 1'b0;
    end else if (arm_i) begin
      sq_seen_q <= 1'b0;
      mu_seen_q <= ~need_mul_i;  // unlaunched product counts as done
    end else begin
      if (sqr_done_i) sq_seen_q <= 1'b1;
      if (mul_done_i) mu_seen_q <= 1'b1;
    end
  end

  assign both_o = (sq_seen_q | sqr_done_i) & (mu_seen_q | mul_done_i);

  p_no_done_at_arm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> !(sqr_done_i || mul_done_i));
endmodule

// File: rtl/rl_exp_pingpong.sv
module rl_exp_pingpong #(
  parameter int unsigned N_PAIRS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [N_PAIRS-1:0] flip_i,
  output logic [N_PAIRS-1:0] sel_o
);
  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    logic sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sel_q <= 1'b0;
      else if (clr_i)     sel_q <= 1'b0;
      else if (flip_i[g]) sel_q <= ~sel_q;
    end
    assign sel_o[g] = sel_q;
  end
endmodule

// File: rtl/rl_exp_seq.sv
module rl_exp_seq
  import rl_exp_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] exp_len_i,
  output logic [CNT_W-1:0] exp_idx_o,
  input  logic             exp_bit_i,
  output logic             load_o,
  output logic             sqr_start_o,
  input  logic             sqr_done_i,
  output logic             mul_start_o,
  input  logic             mul_done_i,
  output logic             pwr_sel_o,
  output logic             res_sel_o,
  output logic             busy_o,
  output logic             valid_o
);
  localparam int unsigned PWR = 0;
  localparam int unsigned RES = 1;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] len_q;
  logic             bit_q, valid_q;
  logic             start_acc, arm, step, last, both_done, len_zero;
  logic [1:0]       flip, sel;

  assign start_acc = (state_q == ST_IDLE) && start_i;
  assign arm       = (state_q == ST_ISSUE);
  assign step      = (state_q == ST_WAIT) && both_done;
  assign len_zero  = (len_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LOAD;
      ST_LOAD:  state_d = len_zero ? ST_IDLE : ST_FETCH;
      ST_FETCH: state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (both_done) state_d = last ? ST_IDLE : ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_acc) len_q <= exp_len_i;
      if (arm)       bit_q <= exp_bit_i;
      if (start_acc)
        valid_q <= 1'b0;
      else if (((state_q == ST_LOAD) && len_zero) || (step && last))
        valid_q <= 1'b1;
    end
  end

  rl_exp_bit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_acc),
    .inc_i  (step),
    .len_i  (len_q),
    .idx_o  (exp_idx_o),
    .last_o (last)
  );

  rl_exp_done_join u_join (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .need_mul_i (exp_bit_i),
    .sqr_done_i (sqr_done_i),
    .mul_done_i (mul_done_i),
    .both_o     (both_done)
  );

  assign flip[PWR] = step;
  assign flip[RES] = step & bit_q;

  rl_exp_pingpong #(.N_PAIRS(2)) u_pp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_acc),
    .flip_i (flip),
    .sel_o  (sel)
  );

  assign pwr_sel_o   = sel[PWR];
  assign res_sel_o   = sel[RES];
  assign load_o      = (state_q == ST_LOAD);
  assign sqr_start_o = arm;
  assign mul_start_o = arm & exp_bit_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign valid_o     = valid_q;

  p_sqr_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqr_start_o |=> !sqr_start_o);
  p_mul_with_sqr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_start_o |-> sqr_start_o);
  p_pwr_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (pwr_sel_o != $past(pwr_sel_o)));
  p_res_hold_on_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !bit_q) |=> $stable(res_sel_o));
  p_busy_not_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !valid_o);
  p_zero_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && len_zero) |=> (valid_o && !busy_o));
  p_len_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> $stable(len_q));
endmodule

// File: tb/rl_exp_seq_test.sv
module rl_exp_seq_test;
  localparam int unsigned CNT_W = 13;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] exp_len_i = '0;
  logic [CNT_W-1:0] exp_idx_o;
  logic             exp_bit_i = 1'b0;
  logic             load_o, sqr_start_o, mul_start_o;
  logic             sqr_done_i = 1'b0, mul_done_i = 1'b0;
  logic             pwr_sel_o, res_sel_o, busy_o, valid_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  rl_exp_seq #(.CNT_W(CNT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .exp_len_i(exp_len_i),
    .exp_idx_o(exp_idx_o), .exp_bit_i(exp_bit_i), .load_o(load_o),
    .sqr_start_o(sqr_start_o), .sqr_done_i(sqr_done_i),
    .mul_start_o(mul_start_o), .mul_done_i(mul_done_i),
    .pwr_sel_o(pwr_sel_o), .res_sel_o(res_sel_o),
    .busy_o(busy_o), .valid_o(valid_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural cycle model: 0 idle 1 load 2 fetch 3 issue 4 wait
  int m_st = 0, m_len = 0, m_idx = 0;
  bit m_valid = 0, m_p = 0, m_r = 0, m_bit = 0, m_sd = 0, m_md = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_len = 0; m_idx = 0; m_valid = 0; m_p = 0; m_r = 0;
    end else begin
      case (m_st)
        0: if (start_i) begin
             m_st = 1; m_valid = 0; m_len = int'(exp_len_i);
             m_idx = 0; m_p = 0; m_r = 0;
           end
        1: if (m_len == 0) begin m_st = 0; m_valid = 1; end else m_st = 2;
        2: m_st = 3;
        3: begin m_bit = exp_bit_i; m_sd = 0; m_md = !exp_bit_i; m_st = 4; end
        default: begin
          if (sqr_done_i) m_sd = 1;
          if (mul_done_i) m_md = 1;
          if (m_sd && m_md) begin
            m_p = !m_p;
            if (m_bit) m_r = !m_r;
            m_idx++;
            if (m_idx == m_len) begin m_st = 0; m_valid = 1; end else m_st = 2;
          end
        end
      endcase
    end
  end

  // ---- environment: bit store, multiplier models, operand buffers
  logic [255:0] ebits = '0;
  int     idx_prev = 0, sq_lat = 1, mu_lat = 1, sq_cnt = 0, mu_cnt = 0;
  longint pbuf[2], rbuf[2], base_v = 1, mod_v = 1000003, sq_val = 0, mu_val = 0;
  bit     sq_dst = 0, mu_dst = 0;

  initial begin
    forever begin
      @(negedge clk_i);
      exp_bit_i = ebits[idx_prev[7:0]];
      sqr_done_i = 0; mul_done_i = 0;
      if (sq_cnt > 0) begin
        sq_cnt--;
        if (sq_cnt == 0) begin sqr_done_i = 1; pbuf[sq_dst] = sq_val; end
      end
      if (mu_cnt > 0) begin
        mu_cnt--;
        if (mu_cnt == 0) begin mul_done_i = 1; rbuf[mu_dst] = mu_val; end
      end
      #1;
      if (rst_ni) begin
        chk("R8 busy_o", busy_o, m_st != 0);
        chk("R2 valid_o", valid_o, m_valid);
        chk("R2 load_o", load_o, m_st == 1);
        chk("R3 sqr_start_o", sqr_start_o, m_st == 3);
        chk("R6 mul_start_o", mul_start_o, (m_st == 3) && exp_bit_i);
        chk("R7 pwr_sel_o", pwr_sel_o, m_p);
        chk("R7 res_sel_o", res_sel_o, m_r);
        chk("R4 exp_idx_o", exp_idx_o, m_idx);
      end
      if (load_o) begin pbuf[0] = base_v; rbuf[0] = 1; end
      if (sqr_start_o) begin
        sq_cnt = sq_lat; sq_dst = !pwr_sel_o;
        sq_val = (pbuf[pwr_sel_o] * pbuf[pwr_sel_o]) % mod_v;
      end
      if (mul_start_o) begin
        mu_cnt = mu_lat; mu_dst = !res_sel_o;
        mu_val = (rbuf[res_sel_o] * pbuf[pwr_sel_o]) % mod_v;
      end
      idx_prev = int'(exp_idx_o);
    end
  end

  function automatic longint modpow(longint b, logic [255:0] e, int len, longint m);
    longint r = 1;
    for (int i = len - 1; i >= 0; i--) begin
      r = (r * r) % m;
      if (e[i]) r = (r * b) % m;
    end
    return r;
  endfunction

  task automatic run(input logic [255:0] e, input int len, input longint b,
                     input int sl, input int ml, input int poke);
    ebits = e; base_v = b; sq_lat = sl; mu_lat = ml;
    @(negedge clk_i); start_i = 1; exp_len_i = CNT_W'(len);
    @(negedge clk_i); start_i = 0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk_i);
      start_i = 1; exp_len_i = CNT_W'(len + 3);
      @(negedge clk_i); start_i = 0;
      chk("R10 busy after ignored start", busy_o, 1);
    end
    while (!valid_o) @(negedge clk_i);
    #2;
    chk("R8 busy low at finish", busy_o, 0);
    chk("R8 result value", rbuf[res_sel_o], modpow(b, e, len, mod_v));
    if (poke > 0) chk("R10 bits processed", exp_idx_o, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 sqr_start in reset", sqr_start_o, 0);
    chk("R1 selects in reset", {pwr_sel_o, res_sel_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 idx after reset", exp_idx_o, 0);

    run(256'hB, 4, 7, 1, 1, 0);                 // R3 basic
    run(256'h0, 0, 9, 1, 1, 0);                 // R9 zero length
    chk("R9 result sel", res_sel_o, 0);
    chk("R9 result one", rbuf[res_sel_o], 1);
    run(256'h81, 8, 12345, 3, 1, 0);            // R5 squarer slower, R6 zeros
    run(256'h5A3C7, 20, 987654, 1, 4, 0);       // R5 product slower
    run(256'hFFF, 12, 31337, 2, 2, 6);          // R10 start mid-run
    repeat (5) @(negedge clk_i);
    chk("R11 valid held while idle", valid_o, 1);
    run(256'h0, 1, 55, 2, 1, 0);                // R6 single zero bit
    chk("R6 result untouched", res_sel_o, 0);
    run(256'h3, 10, 424242, 1, 3, 0);           // R4 high zero bits

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule